// File: doc/BRIEF.md
# Descriptor-Chained DMA Command Sequencer

This block runs one DMA channel from a list of commands kept in memory. Each command is a 16-byte descriptor of four little-endian words. The sequencer reads a descriptor through a word-wide memory port and decodes it. It then does one of four things: hands a data move to a device-side mover, performs a single word load or store itself, does nothing (a no-op), or halts. When the command completes, the sequencer writes the descriptor back with the status and residual count filled in. It then steps to the next descriptor or takes a branch.

Each descriptor can make three choices based on a 4-bit device status nibble held in the status register: whether to hold at completion, whether to pulse the interrupt, and whether to branch. A bad descriptor (an illegal key, a zero data address or an unknown opcode) marks the channel dead and stops it. Software-side control reaches the block as a masked write of the status bits and as a command-pointer load, both presented on plain input ports.

Top module: `dma_desc_seq`

## Requirements
- R1: After reset, status_o, cmdptr_o, irq_o, mem_req_o and xfer_req_o are all zero.
- R2: A pointer load stores ptr_i with bits 3:0 forced to zero. The load is ignored while status RUN (bit 15) or ACTIVE (bit 10) is set.
- R3: A control write replaces the status bits selected by ctl_mask_i with ctl_val_i. Only RUN(15), PAUSE(14), FLUSH(13), WAKE(12) and the device nibble (3:0) can be written. RUN going 0 to 1 sets ACTIVE and clears DEAD(11). RUN going 1 to 0 clears ACTIVE and DEAD. PAUSE set clears ACTIVE.
- R4: A descriptor is fetched only while RUN and ACTIVE are set. The fetch is four word reads at cmdptr, +4, +8 and +12, and it clears WAKE. Word 0 holds the command in bits 31:16 and the request count in bits 15:0. Word 1 is the data address, word 2 the dependent word, and word 3 holds the transfer status in bits 31:16 and the residual in bits 15:0.
- R5: The opcode is command bits 15:12: 0 out-more, 1 out-last, 2 in-more, 3 in-last, 4 store-word, 5 load-word, 6 no-op, 7 stop. A data move drives a transfer with its direction, address, length and a last flag, and holds it until xfer_done_i. The move is refused if the key (command bits 10:8) is above 3 or the address is zero.
- R6: On completion, word 3 becomes {status, residual}, and all four words are written back in order at cmdptr. The residual is xfer_resid_i for data moves and is left unchanged otherwise.
- R7: Condition codes are 0 never, 1 if-match, 2 if-no-match and 3 always. A select byte matches when (nibble & sel[7:4]) == (sel[3:0] & sel[7:4]). Branch (command bits 3:2) applies to data moves and no-ops. A taken branch loads cmdptr from word 2 and sets BT (bit 8). Otherwise cmdptr advances by 16 and BT clears.
- R8: Wait (command bits 1:0, select wait_sel_i) holds the command at completion while the condition is true. The status written back is the one present when the hold releases.
- R9: Interrupt (command bits 5:4, select intr_sel_i) gives a one-cycle irq_o pulse after the write-back.
- R10: A refused command sets DEAD, clears ACTIVE and pulses irq_o. It makes no write-back and leaves cmdptr unchanged.
- R11: Stop clears ACTIVE, DEAD and FLUSH. It makes no write-back and leaves cmdptr unchanged.
- R12: FLUSH is cleared after out-last, in-last, load-word and store-word complete. It is kept after more-form moves and no-ops.
- R13: A word load or store needs key 6; any other key refuses it. A load reads the word at the data address into word 2. A store writes word 2 to the data address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Masked status write strobe |
| ctl_mask_i | input | 16 | Bits of status to replace |
| ctl_val_i | input | 16 | New values for masked bits |
| ptr_we_i | input | 1 | Command pointer load strobe |
| ptr_i | input | ADDR_W | Command pointer value |
| intr_sel_i | input | 8 | Interrupt condition select (mask 7:4, value 3:0) |
| wait_sel_i | input | 8 | Wait condition select |
| branch_sel_i | input | 8 | Branch condition select |
| status_o | output | 16 | Channel status |
| cmdptr_o | output | ADDR_W | Current descriptor address |
| mem_req_o | output | 1 | Memory request, held until ack |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory completion |
| mem_rdata_i | input | 32 | Read data, valid with ack |
| xfer_req_o | output | 1 | Transfer request, held until done |
| xfer_out_o | output | 1 | 1 = memory to device |
| xfer_last_o | output | 1 | Last-form move |
| xfer_addr_o | output | ADDR_W | Transfer address |
| xfer_len_o | output | 16 | Requested byte count |
| xfer_done_i | input | 1 | Transfer finished |
| xfer_resid_i | input | 16 | Bytes left, valid with done |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The hardest case to reach is a wait hold. A no-op reached through a taken branch parks at completion because a device status bit matches the wait select. It must issue no write-back for tens of cycles and ignore a pointer load attempted in that window. Once a control write clears the bit, it must write back the status of that moment, with BT still set. The stimulus builds that chain in the memory model, primes the nibble in the same write that starts the channel, then releases the hold late. Refusal paths are reached by restarting the channel on descriptors with key 4, a zero address or a non-system key, toggling RUN between them to clear DEAD.

// File: rtl/dbseq_pkg.sv
package dbseq_pkg;
  localparam int DESC_WORDS = 4;
  localparam int DESC_BYTES = DESC_WORDS * 4;

  localparam int ST_RUN    = 15;
  localparam int ST_PAUSE  = 14;
  localparam int ST_FLUSH  = 13;
  localparam int ST_WAKE   = 12;
  localparam int ST_DEAD   = 11;
  localparam int ST_ACTIVE = 10;
  localparam int ST_BT     = 8;

  localparam logic [15:0] ST_WRITABLE = 16'hF00F;

  localparam logic [3:0] OP_OUT_MORE = 4'd0;
  localparam logic [3:0] OP_OUT_LAST = 4'd1;
  localparam logic [3:0] OP_IN_MORE  = 4'd2;
  localparam logic [3:0] OP_IN_LAST  = 4'd3;
  localparam logic [3:0] OP_STORE    = 4'd4;
  localparam logic [3:0] OP_LOAD     = 4'd5;
  localparam logic [3:0] OP_NOP      = 4'd6;
  localparam logic [3:0] OP_STOP     = 4'd7;

  localparam logic [2:0] KEY_STREAM_MAX = 3'd3;
  localparam logic [2:0] KEY_SYSTEM     = 3'd6;

  typedef enum logic [1:0] {
    CC_NEVER = 2'd0,
    CC_MATCH = 2'd1,
    CC_MISS  = 2'd2,
    CC_ALWAYS = 2'd3
  } cond_code_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_XFER, S_WMEM, S_WAIT, S_WB, S_FIN
  } seq_state_e;
endpackage

// File: rtl/dbseq_cond.sv
module dbseq_cond
  import dbseq_pkg::*;
(
  input  logic [1:0] code_i,
  input  logic [3:0] devstat_i,
  input  logic [7:0] sel_i,
  output logic       hit_o
);
  logic match;
  assign match = ((devstat_i & sel_i[7:4]) == (sel_i[3:0] & sel_i[7:4]));

  always_comb begin
    unique case (cond_code_e'(code_i))
      CC_NEVER:  hit_o = 1'b0;
      CC_MATCH:  hit_o = match;
      CC_MISS:   hit_o = ~match;
      default:   hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dbseq_ctrl.sv
module dbseq_ctrl
  import dbseq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [15:0]       ctl_mask_i,
  input  logic [15:0]       ctl_val_i,
  input  logic              ptr_we_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              ev_fetch_i,
  input  logic              ev_kill_i,
  input  logic              ev_stop_i,
  input  logic              ev_flush_clr_i,
  input  logic              ev_next_i,
  input  logic              ev_branch_i,
  input  logic [ADDR_W-1:0] dep_i,
  output logic [15:0]       status_o,
  output logic [ADDR_W-1:0] cmdptr_o
);
  localparam logic [ADDR_W-1:0] ALIGN = ~ADDR_W'(DESC_BYTES - 1);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(DESC_BYTES);

  logic [15:0]       status_q, status_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    logic [15:0] m;
    logic [15:0] nv;
    status_d = status_q;
    if (ev_fetch_i) status_d[ST_WAKE] = 1'b0;
    if (ev_kill_i) begin
      status_d[ST_DEAD]   = 1'b1;
      status_d[ST_ACTIVE] = 1'b0;
    end
    if (ev_stop_i) begin
      status_d[ST_ACTIVE] = 1'b0;
      status_d[ST_DEAD]   = 1'b0;
      status_d[ST_FLUSH]  = 1'b0;
    end
    if (ev_flush_clr_i) status_d[ST_FLUSH] = 1'b0;
    if (ev_next_i)      status_d[ST_BT]    = 1'b0;
    if (ev_branch_i)    status_d[ST_BT]    = 1'b1;
    m  = ctl_mask_i & ST_WRITABLE;
    nv = (ctl_val_i & m) | (status_d & ~m);
    if (ctl_we_i) begin
      if (nv[ST_RUN] && !status_q[ST_RUN]) begin
        nv[ST_ACTIVE] = 1'b1;
        nv[ST_DEAD]   = 1'b0;
      end
      if (nv[ST_PAUSE]) nv[ST_ACTIVE] = 1'b0;
      if (!nv[ST_RUN] && status_q[ST_RUN]) begin
        nv[ST_ACTIVE] = 1'b0;
        nv[ST_DEAD]   = 1'b0;
      end
      status_d = nv;
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (ev_next_i)
      ptr_d = ptr_q + STEP;
    else if (ev_branch_i)
      ptr_d = dep_i & ALIGN;
    else if (ptr_we_i && !status_q[ST_RUN] && !status_q[ST_ACTIVE])
      ptr_d = ptr_i & ALIGN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      ptr_q    <= '0;
    end else begin
      status_q <= status_d;
      ptr_q    <= ptr_d;
    end
  end

  assign status_o = status_q;
  assign cmdptr_o = ptr_q;

  p_dead_inactive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_q[ST_DEAD] |-> !status_q[ST_ACTIVE]);

  p_ptr_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_we_i && (status_q[ST_RUN] || status_q[ST_ACTIVE]) && !ev_next_i && !ev_branch_i)
    |=> $stable(ptr_q));
endmodule

// File: rtl/dbseq_engine.sv
module dbseq_engine
  import dbseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       status_i,
  input  logic [ADDR_W-1:0] cmdptr_i,
  input  logic [7:0]        intr_sel_i,
  input  logic [7:0]        wait_sel_i,
  input  logic [7:0]        branch_sel_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              xfer_req_o,
  output logic              xfer_out_o,
  output logic              xfer_last_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic [CNT_W-1:0]  xfer_len_o,
  input  logic              xfer_done_i,
  input  logic [CNT_W-1:0]  xfer_resid_i,
  output logic              irq_o,
  output logic              ev_fetch_o,
  output logic              ev_kill_o,
  output logic              ev_stop_o,
  output logic              ev_flush_clr_o,
  output logic              ev_next_o,
  output logic              ev_branch_o,
  output logic [ADDR_W-1:0] dep_o
);
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam int N_COND = 3;

  seq_state_e state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic [DESC_WORDS-1:0][31:0] desc_q;

  logic [3:0] opcode;
  logic [2:0] key;
  logic       is_move, is_word, is_store, is_last;
  logic [ADDR_W-1:0] data_addr, word_addr;

  assign opcode    = desc_q[0][31:28];
  assign key       = desc_q[0][26:24];
  assign is_move   = (opcode <= OP_IN_LAST);
  assign is_word   = (opcode == OP_STORE) || (opcode == OP_LOAD);
  assign is_store  = (opcode == OP_STORE);
  assign is_last   = is_move && opcode[0];
  assign data_addr = desc_q[1][ADDR_W-1:0];
  assign word_addr = cmdptr_i + ADDR_W'({idx_q, 2'b00});
  assign dep_o     = desc_q[2][ADDR_W-1:0];

  // index 2: interrupt, 1: branch, 0: wait
  logic [N_COND-1:0][1:0] cc_code;
  logic [N_COND-1:0][7:0] cc_sel;
  logic [N_COND-1:0]      cc_hit;
  assign cc_code = {desc_q[0][21:20], desc_q[0][19:18], desc_q[0][17:16]};
  assign cc_sel  = {intr_sel_i, branch_sel_i, wait_sel_i};

  for (genvar g = 0; g < N_COND; g++) begin : g_cond
    dbseq_cond u_cond (
      .code_i   (cc_code[g]),
      .devstat_i(status_i[3:0]),
      .sel_i    (cc_sel[g]),
      .hit_o    (cc_hit[g])
    );
  end

  logic wait_hit, br_hit, intr_hit;
  assign wait_hit = cc_hit[0];
  assign br_hit   = cc_hit[1];
  assign intr_hit = cc_hit[2];

  always_comb begin
    state_d        = state_q;
    mem_req_o      = 1'b0;
    mem_we_o       = 1'b0;
    mem_addr_o     = word_addr;
    mem_wdata_o    = desc_q[idx_q];
    xfer_req_o     = 1'b0;
    irq_o          = 1'b0;
    ev_fetch_o     = 1'b0;
    ev_kill_o      = 1'b0;
    ev_stop_o      = 1'b0;
    ev_flush_clr_o = 1'b0;
    ev_next_o      = 1'b0;
    ev_branch_o    = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (status_i[ST_RUN] && status_i[ST_ACTIVE]) begin
          ev_fetch_o = 1'b1;
          state_d    = S_FETCH;
        end
      end
      S_FETCH: begin
        mem_req_o = 1'b1;
        if (mem_ack_i && idx_q == IDX_W'(DESC_WORDS - 1)) state_d = S_DECODE;
      end
      S_DECODE: begin
        if (opcode == OP_STOP) begin
          ev_stop_o = 1'b1;
          state_d   = S_IDLE;
        end else if (opcode == OP_NOP) begin
          state_d = S_WAIT;
        end else if (is_move && key <= KEY_STREAM_MAX && data_addr != '0) begin
          state_d = S_XFER;
        end else if (is_word && key == KEY_SYSTEM) begin
          state_d = S_WMEM;
        end else begin
          ev_kill_o = 1'b1;
          irq_o     = 1'b1;
          state_d   = S_IDLE;
        end
      end
      S_XFER: begin
        xfer_req_o = 1'b1;
        if (xfer_done_i) state_d = S_WAIT;
      end
      S_WMEM: begin
        mem_req_o   = 1'b1;
        mem_we_o    = is_store;
        mem_addr_o  = data_addr;
        mem_wdata_o = desc_q[2];
        if (mem_ack_i) state_d = S_WAIT;
      end
      S_WAIT: begin
        if (!wait_hit) state_d = S_WB;
      end
      S_WB: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_ack_i && idx_q == IDX_W'(DESC_WORDS - 1)) state_d = S_FIN;
      end
      S_FIN: begin
        irq_o          = intr_hit;
        ev_flush_clr_o = is_last || is_word;
        if (!is_word && br_hit) ev_branch_o = 1'b1;
        else                    ev_next_o   = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      desc_q  <= '0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        S_IDLE: idx_q <= '0;
        S_FETCH: if (mem_ack_i) begin
          desc_q[idx_q] <= mem_rdata_i;
          idx_q         <= idx_q + 1'b1;
        end
        S_XFER: if (xfer_done_i) desc_q[3][CNT_W-1:0] <= xfer_resid_i;
        S_WMEM: if (mem_ack_i && !is_store) desc_q[2] <= mem_rdata_i;
        S_WAIT: if (!wait_hit) begin
          desc_q[3][31:16] <= status_i;
          idx_q            <= '0;
        end
        S_WB: if (mem_ack_i) idx_q <= idx_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign xfer_out_o  = ~opcode[1];
  assign xfer_last_o = is_last;
  assign xfer_addr_o = data_addr;
  assign xfer_len_o  = desc_q[0][CNT_W-1:0];

  p_mem_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_xfer_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !xfer_done_i) |=> (xfer_req_o && $stable(xfer_addr_o) && $stable(xfer_len_o)));

  p_irq_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_no_overlap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && xfer_req_o));

  p_stop_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_stop_o |=> !mem_req_o);
endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
  import dbseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [15:0]       ctl_mask_i,
  input  logic [15:0]       ctl_val_i,
  input  logic              ptr_we_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [7:0]        intr_sel_i,
  input  logic [7:0]        wait_sel_i,
  input  logic [7:0]        branch_sel_i,
  output logic [15:0]       status_o,
  output logic [ADDR_W-1:0] cmdptr_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              xfer_req_o,
  output logic              xfer_out_o,
  output logic              xfer_last_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic [CNT_W-1:0]  xfer_len_o,
  input  logic              xfer_done_i,
  input  logic [CNT_W-1:0]  xfer_resid_i,
  output logic              irq_o
);
  logic ev_fetch, ev_kill, ev_stop, ev_flush_clr, ev_next, ev_branch;
  logic [ADDR_W-1:0] dep;

  dbseq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni,
    .ctl_we_i, .ctl_mask_i, .ctl_val_i,
    .ptr_we_i, .ptr_i,
    .ev_fetch_i    (ev_fetch),
    .ev_kill_i     (ev_kill),
    .ev_stop_i     (ev_stop),
    .ev_flush_clr_i(ev_flush_clr),
    .ev_next_i     (ev_next),
    .ev_branch_i   (ev_branch),
    .dep_i         (dep),
    .status_o, .cmdptr_o
  );

  dbseq_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_engine (
    .clk_i, .rst_ni,
    .status_i (status_o),
    .cmdptr_i (cmdptr_o),
    .intr_sel_i, .wait_sel_i, .branch_sel_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .xfer_req_o, .xfer_out_o, .xfer_last_o, .xfer_addr_o, .xfer_len_o,
    .xfer_done_i, .xfer_resid_i,
    .irq_o,
    .ev_fetch_o    (ev_fetch),
    .ev_kill_o     (ev_kill),
    .ev_stop_o     (ev_stop),
    .ev_flush_clr_o(ev_flush_clr),
    .ev_next_o     (ev_next),
    .ev_branch_o   (ev_branch),
    .dep_o         (dep)
  );
endmodule

// File: tb/dma_desc_seq_tb_top.sv
module dma_desc_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        ctl_we = 0, ptr_we = 0;
  logic [15:0] ctl_mask = 0, ctl_val = 0;
  logic [31:0] ptr = 0;
  logic [7:0]  intr_sel = 0, wait_sel = 0, branch_sel = 0;
  logic [15:0] status;
  logic [31:0] cmdptr, mem_addr, mem_wdata, xfer_addr;
  logic        mem_req, mem_we, xfer_req, xfer_out, xfer_last, irq;
  logic        mem_ack = 0, xfer_done = 0;
  logic [31:0] mem_rdata = 0;
  logic [15:0] xfer_len, xfer_resid = 16'd2;

  dma_desc_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_we_i(ctl_we), .ctl_mask_i(ctl_mask), .ctl_val_i(ctl_val),
    .ptr_we_i(ptr_we), .ptr_i(ptr),
    .intr_sel_i(intr_sel), .wait_sel_i(wait_sel), .branch_sel_i(branch_sel),
    .status_o(status), .cmdptr_o(cmdptr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .xfer_req_o(xfer_req), .xfer_out_o(xfer_out), .xfer_last_o(xfer_last),
    .xfer_addr_o(xfer_addr), .xfer_len_o(xfer_len),
    .xfer_done_i(xfer_done), .xfer_resid_i(xfer_resid),
    .irq_o(irq)
  );

  logic [31:0] mem [0:255];
  int checks = 0, errors = 0, irq_cnt = 0, cyc = 0;
  logic [63:0] exp_wr[$], act_wr[$], exp_xf[$], act_xf[$];
  logic xf_seen = 0;

  // memory model: ack one cycle after a request
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  // device model: done four cycles into a request
  int dcnt = 0;
  always @(posedge clk) begin
    xfer_done <= 1'b0;
    if (xfer_req && !xfer_done) begin
      if (dcnt == 3) begin xfer_done <= 1'b1; dcnt <= 0; end
      else dcnt <= dcnt + 1;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (irq) irq_cnt <= irq_cnt + 1;
    if (mem_req && mem_we && mem_ack) act_wr.push_back({mem_addr, mem_wdata});
    if (xfer_req && !xf_seen)
      act_xf.push_back({14'd0, xfer_out, xfer_last, xfer_len, xfer_addr});
    xf_seen <= xfer_req;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ctl(logic [15:0] m, logic [15:0] v);
    @(negedge clk); ctl_we = 1; ctl_mask = m; ctl_val = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic load_ptr(logic [31:0] p);
    @(negedge clk); ptr_we = 1; ptr = p;
    @(negedge clk); ptr_we = 0;
  endtask

  task automatic put_desc(int base, logic [31:0] w0, w1, w2, w3);
    mem[base/4] = w0; mem[base/4+1] = w1; mem[base/4+2] = w2; mem[base/4+3] = w3;
  endtask

  task automatic exp_wb(int base, logic [31:0] w0, w1, w2, w3);
    exp_wr.push_back({base[31:0], w0});
    exp_wr.push_back({base[31:0] + 32'd4, w1});
    exp_wr.push_back({base[31:0] + 32'd8, w2});
    exp_wr.push_back({base[31:0] + 32'd12, w3});
  endtask

  task automatic settle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!status[10] && !mem_req && !xfer_req) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp_logs(string req);
    chk({req, " write count"}, act_wr.size(), exp_wr.size());
    for (int i = 0; i < exp_wr.size() && i < act_wr.size(); i++)
      chk({req, " write"}, act_wr[i], exp_wr[i]);
    chk({req, " xfer count"}, act_xf.size(), exp_xf.size());
    for (int i = 0; i < exp_xf.size() && i < act_xf.size(); i++)
      chk({req, " xfer"}, act_xf[i], exp_xf[i]);
    exp_wr.delete(); act_wr.delete(); exp_xf.delete(); act_xf.delete();
  endtask

  always @(negedge clk) if (cyc > 100000) begin
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int irq0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 0);
    chk("R1 cmdptr", cmdptr, 0);
    chk("R1 outputs", {irq, mem_req, xfer_req}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // S1: out-more then in-last with interrupt, then stop (R2 R4 R5 R6 R9 R12 R11)
    put_desc(32'h40, 32'h0000_0008, 32'h200, 32'h1111_1111, 32'h0);
    put_desc(32'h50, 32'h3130_0004, 32'h300, 32'h0, 32'h0);
    put_desc(32'h60, 32'h7000_0000, 32'h0, 32'h0, 32'h0);
    load_ptr(32'h44);
    chk("R2 aligned load", cmdptr, 32'h40);
    exp_wb(32'h40, 32'h0000_0008, 32'h200, 32'h1111_1111, 32'hA400_0002);
    exp_wb(32'h50, 32'h3130_0004, 32'h300, 32'h0, 32'hA400_0002);
    exp_xf.push_back({14'd0, 1'b1, 1'b0, 16'd8, 32'h200});
    exp_xf.push_back({14'd0, 1'b0, 1'b1, 16'd4, 32'h300});
    irq0 = irq_cnt;
    ctl(16'hA000, 16'hA000);
    settle();
    cmp_logs("R5 R6 R12 chain");
    chk("R9 irq on last", irq_cnt - irq0, 1);
    chk("R11 stop status", status, 16'h8000);
    chk("R11 stop ptr", cmdptr, 32'h60);

    // S2: branch, wait hold, WAKE clear (R3 R4 R7 R8 R2)
    ctl(16'h8000, 16'h0000);
    chk("R3 run fall", status, 16'h0000);
    load_ptr(32'h80);
    put_desc(32'h80, 32'h6004_0000, 32'h0, 32'hC0, 32'h0000_0055);
    put_desc(32'hC0, 32'h6001_0000, 32'h0, 32'h0, 32'h0000_0066);
    put_desc(32'hD0, 32'h7000_0000, 32'h0, 32'h0, 32'h0);
    branch_sel = 8'h11; wait_sel = 8'h22;
    ctl(16'h900F, 16'h9003);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (cmdptr == 32'hC0) break;
    end
    repeat (40) @(negedge clk);
    chk("R8 held no writeback", act_wr.size(), 4);
    chk("R7 branch BT set", status, 16'h8503);
    load_ptr(32'h200);
    chk("R2 ignored while running", cmdptr, 32'hC0);
    exp_wb(32'h80, 32'h6004_0000, 32'h0, 32'hC0, 32'h8403_0055);
    exp_wb(32'hC0, 32'h6001_0000, 32'h0, 32'h0, 32'h8501_0066);
    ctl(16'h0002, 16'h0000);
    settle();
    cmp_logs("R4 R7 R8 branch and wait");
    chk("R7 next clears BT", status, 16'h8001);
    chk("R11 ptr at stop", cmdptr, 32'hD0);

    // S3: refusals (R10 R5 R13 R3)
    ctl(16'h800F, 16'h0000);
    irq0 = irq_cnt;
    load_ptr(32'h100);
    put_desc(32'h100, 32'h1400_0004, 32'h200, 32'h0, 32'h0);
    ctl(16'h8000, 16'h8000);
    settle();
    chk("R10 key4 dead", status, 16'h8800);
    chk("R10 ptr kept", cmdptr, 32'h100);
    ctl(16'h8000, 16'h0000);
    chk("R3 run fall clears dead", status, 16'h0000);
    load_ptr(32'h110);
    put_desc(32'h110, 32'h2000_0004, 32'h0, 32'h0, 32'h0);
    ctl(16'h8000, 16'h8000);
    settle();
    chk("R5 zero address dead", status, 16'h8800);
    ctl(16'h8000, 16'h0000);
    load_ptr(32'h120);
    put_desc(32'h120, 32'h5000_0000, 32'h3F0, 32'h0, 32'h0);
    ctl(16'h8000, 16'h8000);
    settle();
    chk("R13 non-system key dead", status, 16'h8800);
    chk("R10 irq per refusal", irq_cnt - irq0, 3);
    cmp_logs("R10 no writeback");

    // S4: load and store words (R13 R12 R9)
    ctl(16'h8000, 16'h0000);
    load_ptr(32'h140);
    mem[32'h3F0/4] = 32'hDEAD_BEEF;
    put_desc(32'h140, 32'h5610_0004, 32'h3F0, 32'h0, 32'h0000_00AA);
    put_desc(32'h150, 32'h4620_0004, 32'h3F4, 32'h1234_5678, 32'h0);
    put_desc(32'h160, 32'h7000_0000, 32'h0, 32'h0, 32'h0);
    intr_sel = 8'h11;
    exp_wb(32'h140, 32'h5610_0004, 32'h3F0, 32'hDEAD_BEEF, 32'hA400_00AA);
    exp_wr.push_back({32'h3F4, 32'h1234_5678});
    exp_wb(32'h150, 32'h4620_0004, 32'h3F4, 32'h1234_5678, 32'h8400_0000);
    irq0 = irq_cnt;
    ctl(16'hA00F, 16'hA000);
    settle();
    cmp_logs("R13 R12 word ops");
    chk("R9 if-no-match irq only", irq_cnt - irq0, 1);
    chk("R13 stored word", mem[32'h3F4/4], 32'h1234_5678);
    chk("R11 final status", status, 16'h8000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule